// File: doc/BRIEF.md
# T1/E1 Transmit Line Encoder

This block is the digital half of a primary-rate transmit line interface. It picks one of two sources, each a data pair with a bit-clock strobe: the normal transmit source or a loopback source. On every strobe of the chosen source it takes one bit. The bit is read either as single-rail NRZ data or as dual-rail bipolar marks. An alarm input overrides the data with all ones. The resulting positive and negative mark rails feed an analog waveshaper that lies outside this block.

Every bit passes through an eight-position lookahead window, so the output is always eight strobes behind the input. While zero suppression is enabled, the window is scanned for runs of spaces. At the T1 rate a run of eight spaces becomes a B8ZS code word. At the E1 rate a run of four spaces becomes an HDB3 code word. The choice between a violation and a balancing pulse is made only when a bit leaves the window. That choice uses the polarity of the last mark actually sent and the count of marks sent since the last violation.

The output stage is a two-state machine that remembers the last mark polarity. Its states are LAST_POS and LAST_NEG, and reset enters LAST_NEG. Sending a positive mark moves it to LAST_POS. Sending a negative mark moves it to LAST_NEG. A space leaves the state where it is. All logic runs on one system clock, and the line clocks arrive as one-cycle strobes.

Top module: `t1e1_tx_encoder`

## Requirements
- R1: With `lb_sel`=0, bits are taken from `norm_pos`/`norm_neg` on `norm_stb`, and `loop_*` has no effect. With `lb_sel`=1, bits are taken from `loop_pos`/`loop_neg` on `loop_stb`, and `norm_*` has no effect. A strobe of the unselected source produces no bit and leaves the rails unchanged.
- R2: Each selected strobe makes `bit_stb` high for exactly one cycle, in the cycle after the strobe. The rails change only in that cycle and hold their value otherwise.
- R3: The bit taken at selected strobe k appears on the rails in the cycle after selected strobe k+8, in every mode. The first eight bits after reset are spaces.
- R4: With `uni_mode`=1, the bit is `*_pos` (the negative rail is ignored), where 1 is a mark. Marks alternate polarity (AMI), and the first mark after reset is positive (`mark_p`).
- R5: With `uni_mode`=0, `*_pos`=1 gives a positive mark, `*_pos`=0 with `*_neg`=1 gives a negative mark, and 00 gives a space. A positive mark drives `mark_p`=1 and a negative mark drives `mark_n`=1.
- R6: While `alarm_on`=1 at a strobe, the bit taken is a mark regardless of the data. Such marks alternate polarity with respect to the last mark sent.
- R7: With `zs_en`=0 at the strobe that completes a run, spaces are sent as spaces. Zero-suppression enable, rate and format settings are read at each strobe.
- R8: With `zs_en`=1 and `rate_e1`=0, eight consecutive unsubstituted spaces are sent as 0,0,0,V,B,0,V,B, oldest first. V has the polarity of the mark sent just before it. B has the opposite polarity.
- R9: With `zs_en`=1 and `rate_e1`=1, four consecutive unsubstituted spaces are sent as 0,0,0,V when an odd number of marks has been sent since the last violation. They are sent as B,0,0,V when that number is even, and reset starts with a count of zero. B is opposite to the last mark, V repeats the last mark's polarity, and each violation clears the count.
- R10: `mark_p` and `mark_n` are never high together.
- R11: After reset, `mark_p`, `mark_n` and `bit_stb` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lb_sel | input | 1 | 0: normal source, 1: loopback source |
| norm_stb | input | 1 | Normal line-clock strobe (falling-edge event) |
| norm_pos | input | 1 | Normal positive / NRZ data rail |
| norm_neg | input | 1 | Normal negative data rail |
| loop_stb | input | 1 | Loopback line-clock strobe |
| loop_pos | input | 1 | Loopback positive / NRZ data rail |
| loop_neg | input | 1 | Loopback negative data rail |
| uni_mode | input | 1 | 1: single-rail NRZ, block applies AMI; 0: dual-rail bipolar |
| alarm_on | input | 1 | Force all-ones marks |
| zs_en | input | 1 | Enable zero-run substitution |
| rate_e1 | input | 1 | 0: T1 (B8ZS), 1: E1 (HDB3) |
| mark_p | output | 1 | Positive mark rail to waveshaper |
| mark_n | output | 1 | Negative mark rail to waveshaper |
| bit_stb | output | 1 | High in the cycle a new bit is placed on the rails |

## Verification
The bench aims at several corner cases, and each has a typical failure. Runs of spaces that overlap a code word already tagged should not be substituted a second time; a design that retags them would emit extra violations. A run that starts directly after reset must not consume the reset fill; if it did, code words would appear within the first eight bits. A pulse from the unselected source must not move the window. An HDB3 parity count that ignored the mark leaving the window on the same strobe would choose 000V where B00V is due and break the alternation of violations. Random mixes of format, alarm bursts, source changes and rate changes check every emitted bit against an independent stream model. A slip of one strobe in the delay would fail nearly every check.

// File: rtl/t1e1_enc_pkg.sv
package t1e1_enc_pkg;

    localparam int LOOKAHEAD = 8;   // pipeline depth in bits
    localparam int B8_RUN    = 8;   // zero run replaced at the T1 rate
    localparam int HDB_RUN   = 4;   // zero run replaced at the E1 rate

    // substitution tag carried by each bit in the window
    typedef enum logic [2:0] {
        TG_NONE,   // plain bit, encode by its own flags
        TG_ZERO,   // space that belongs to a code word (or reset fill)
        TG_VIOL,   // violation: same polarity as last mark
        TG_BIP,    // balancing pulse: opposite to last mark
        TG_HEAD    // HDB3 head: B or space, by mark parity
    } tag_e;

    typedef struct packed {
        logic mark;   // 1 = mark
        logic neg;    // given polarity (bipolar input)
        logic ami;    // polarity to be chosen by alternation
        tag_e tag;
    } sym_t;

endpackage

// File: rtl/t1e1_src_sel.sv
module t1e1_src_sel
    import t1e1_enc_pkg::*;
(
    input  logic lb_sel,
    input  logic norm_stb,
    input  logic norm_pos,
    input  logic norm_neg,
    input  logic loop_stb,
    input  logic loop_pos,
    input  logic loop_neg,
    input  logic uni_mode,
    input  logic alarm_on,
    output logic take,
    output sym_t sym
);

    logic pos_sel;
    logic neg_sel;

    always_comb begin
        take    = lb_sel ? loop_stb : norm_stb;
        pos_sel = lb_sel ? loop_pos : norm_pos;
        neg_sel = lb_sel ? loop_neg : norm_neg;

        sym.tag = TG_NONE;
        if (alarm_on) begin
            sym.mark = 1'b1;
            sym.neg  = 1'b0;
            sym.ami  = 1'b1;
        end else if (uni_mode) begin
            sym.mark = pos_sel;
            sym.neg  = 1'b0;
            sym.ami  = 1'b1;
        end else begin
            sym.mark = pos_sel | neg_sel;
            sym.neg  = ~pos_sel & neg_sel;
            sym.ami  = 1'b0;
        end
    end

endmodule

// File: rtl/t1e1_zs_window.sv
module t1e1_zs_window
    import t1e1_enc_pkg::*;
#(
    parameter int WIN = LOOKAHEAD
)(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  sym_t in_sym,
    input  logic zs_en,
    input  logic rate_e1,
    output sym_t oldest
);

    sym_t ent [WIN];
    sym_t shf [WIN];
    sym_t nxt [WIN];
    logic run_b8;
    logic run_hd;

    function automatic logic free_zero(input sym_t s);
        return (!s.mark) && (s.tag == TG_NONE);
    endfunction

    // index 0 = newest bit; code word written oldest first is 000VB0VB
    function automatic tag_e b8_code(input int j);
        case (j)
            0:       return TG_BIP;
            1:       return TG_VIOL;
            3:       return TG_BIP;
            4:       return TG_VIOL;
            default: return TG_ZERO;
        endcase
    endfunction

    function automatic tag_e hd_code(input int j);
        case (j)
            0:       return TG_VIOL;
            3:       return TG_HEAD;
            default: return TG_ZERO;
        endcase
    endfunction

    assign shf[0] = in_sym;
    for (genvar i = 1; i < WIN; i++) begin : g_shift
        assign shf[i] = ent[i-1];
    end

    always_comb begin
        run_b8 = 1'b1;
        for (int j = 0; j < B8_RUN; j++) begin
            if (!free_zero(shf[j])) run_b8 = 1'b0;
        end
        run_hd = 1'b1;
        for (int j = 0; j < HDB_RUN; j++) begin
            if (!free_zero(shf[j])) run_hd = 1'b0;
        end
        for (int j = 0; j < WIN; j++) nxt[j] = shf[j];
        if (zs_en && !rate_e1 && run_b8) begin
            for (int j = 0; j < B8_RUN; j++) nxt[j].tag = b8_code(j);
        end else if (zs_en && rate_e1 && run_hd) begin
            for (int j = 0; j < HDB_RUN; j++) nxt[j].tag = hd_code(j);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < WIN; j++) begin
                ent[j] <= '{mark: 1'b0, neg: 1'b0, ami: 1'b0, tag: TG_ZERO};
            end
        end else if (take) begin
            for (int j = 0; j < WIN; j++) ent[j] <= nxt[j];
        end
    end

    assign oldest = ent[WIN-1];

endmodule

// File: rtl/t1e1_mark_gen.sv
module t1e1_mark_gen
    import t1e1_enc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  sym_t sym,
    output logic mark_p,
    output logic mark_n,
    output logic bit_stb
);

    typedef enum logic {LAST_POS, LAST_NEG} pol_e;

    pol_e st_q;
    pol_e st_nxt;
    logic odd_q;
    logic odd_nxt;
    logic emit;
    logic emit_neg;
    logic opp_neg;
    logic same_neg;

    always_comb begin
        opp_neg  = 1'b0;
        same_neg = 1'b0;
        unique case (st_q)
            LAST_POS: begin opp_neg = 1'b1; same_neg = 1'b0; end
            LAST_NEG: begin opp_neg = 1'b0; same_neg = 1'b1; end
        endcase

        emit     = 1'b0;
        emit_neg = 1'b0;
        unique case (sym.tag)
            TG_NONE: begin
                emit     = sym.mark;
                emit_neg = sym.ami ? opp_neg : sym.neg;
            end
            TG_ZERO: begin
                emit = 1'b0;
            end
            TG_VIOL: begin
                emit     = 1'b1;
                emit_neg = same_neg;
            end
            TG_BIP: begin
                emit     = 1'b1;
                emit_neg = opp_neg;
            end
            TG_HEAD: begin
                emit     = ~odd_q;
                emit_neg = opp_neg;
            end
            default: begin
                emit = 1'b0;
            end
        endcase

        st_nxt = st_q;
        if (emit) st_nxt = emit_neg ? LAST_NEG : LAST_POS;
        odd_nxt = (sym.tag == TG_VIOL) ? 1'b0 : (odd_q ^ emit);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= LAST_NEG;
            odd_q <= 1'b0;
        end else if (take) begin
            st_q  <= st_nxt;
            odd_q <= odd_nxt;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mark_p  <= 1'b0;
            mark_n  <= 1'b0;
            bit_stb <= 1'b0;
        end else begin
            bit_stb <= take;
            if (take) begin
                mark_p <= emit & ~emit_neg;
                mark_n <= emit & emit_neg;
            end
        end
    end

endmodule

// File: rtl/t1e1_tx_encoder.sv
module t1e1_tx_encoder
    import t1e1_enc_pkg::*;
#(
    parameter int WIN = LOOKAHEAD
)(
    input  logic clk,
    input  logic rst_n,
    input  logic lb_sel,
    input  logic norm_stb,
    input  logic norm_pos,
    input  logic norm_neg,
    input  logic loop_stb,
    input  logic loop_pos,
    input  logic loop_neg,
    input  logic uni_mode,
    input  logic alarm_on,
    input  logic zs_en,
    input  logic rate_e1,
    output logic mark_p,
    output logic mark_n,
    output logic bit_stb
);

    logic take;
    sym_t in_sym;
    sym_t out_sym;

    t1e1_src_sel u_src (
        .lb_sel   (lb_sel),
        .norm_stb (norm_stb),
        .norm_pos (norm_pos),
        .norm_neg (norm_neg),
        .loop_stb (loop_stb),
        .loop_pos (loop_pos),
        .loop_neg (loop_neg),
        .uni_mode (uni_mode),
        .alarm_on (alarm_on),
        .take     (take),
        .sym      (in_sym)
    );

    t1e1_zs_window #(.WIN(WIN)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .in_sym  (in_sym),
        .zs_en   (zs_en),
        .rate_e1 (rate_e1),
        .oldest  (out_sym)
    );

    t1e1_mark_gen u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .sym     (out_sym),
        .mark_p  (mark_p),
        .mark_n  (mark_n),
        .bit_stb (bit_stb)
    );

endmodule

// File: rtl/t1e1_tx_encoder_chk.sv
module t1e1_tx_encoder_chk (
    input logic clk,
    input logic rst_n,
    input logic lb_sel,
    input logic norm_stb,
    input logic loop_stb,
    input logic alarm_on,
    input logic mark_p,
    input logic mark_n,
    input logic bit_stb
);

    logic       sel_stb;
    logic [3:0] al_run;
    logic       prev_neg;

    assign sel_stb = lb_sel ? loop_stb : norm_stb;

    // consecutive selected strobes taken with the alarm high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            al_run <= '0;
        end else if (sel_stb) begin
            if (!alarm_on)            al_run <= '0;
            else if (al_run != 4'hF)  al_run <= al_run + 4'd1;
        end
    end

    // polarity of the last mark seen on the rails
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           prev_neg <= 1'b1;
        else if (bit_stb && (mark_p || mark_n)) prev_neg <= mark_n;
    end

    p_rails_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mark_p && mark_n));

    p_bit_after_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_stb |=> bit_stb);

    p_no_stray_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_stb |=> !bit_stb);

    p_rails_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_stb |=> $stable({mark_p, mark_n}));

    p_alarm_ami_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && al_run >= 4'd9) |-> ((mark_p ^ mark_n) && (mark_n == !prev_neg)));

endmodule

bind t1e1_tx_encoder t1e1_tx_encoder_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lb_sel   (lb_sel),
    .norm_stb (norm_stb),
    .loop_stb (loop_stb),
    .alarm_on (alarm_on),
    .mark_p   (mark_p),
    .mark_n   (mark_n),
    .bit_stb  (bit_stb)
);

// File: tb/sim_t1e1_tx_encoder.sv
`timescale 1ns/1ps
module sim_t1e1_tx_encoder;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lb_sel = 1'b0;
    logic norm_stb = 1'b0, norm_pos = 1'b0, norm_neg = 1'b0;
    logic loop_stb = 1'b0, loop_pos = 1'b0, loop_neg = 1'b0;
    logic uni_mode = 1'b1, alarm_on = 1'b0, zs_en = 1'b0, rate_e1 = 1'b0;
    logic mark_p, mark_n, bit_stb;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    t1e1_tx_encoder u0 (
        .clk(clk), .rst_n(rst_n), .lb_sel(lb_sel),
        .norm_stb(norm_stb), .norm_pos(norm_pos), .norm_neg(norm_neg),
        .loop_stb(loop_stb), .loop_pos(loop_pos), .loop_neg(loop_neg),
        .uni_mode(uni_mode), .alarm_on(alarm_on), .zs_en(zs_en), .rate_e1(rate_e1),
        .mark_p(mark_p), .mark_n(mark_n), .bit_stb(bit_stb)
    );

    // stream model: tags 0 plain, 1 code space/fill, 2 V, 3 B, 4 HDB3 head
    bit    m_mark [16];
    bit    m_neg  [16];
    bit    m_ami  [16];
    int    m_tag  [16];
    string m_lbl  [16];
    int    widx;
    bit    last_neg;
    bit    odd_cnt;

    task automatic chk(input bit ok, input string req, input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic bit free_at(input int i);
        return (m_mark[i & 15] == 1'b0) && (m_tag[i & 15] == 0);
    endfunction

    task automatic model_step(input bit u, input bit a, input bit p, input bit q,
                              output bit e_mark, output bit e_neg, output string lbl);
        int  n;
        int  k;
        bit  run;
        n = widx;
        k = n & 15;
        m_tag[k] = 0;
        if (a)      begin m_mark[k] = 1'b1;  m_neg[k] = 1'b0;    m_ami[k] = 1'b1; m_lbl[k] = "R6"; end
        else if (u) begin m_mark[k] = p;     m_neg[k] = 1'b0;    m_ami[k] = 1'b1; m_lbl[k] = "R4"; end
        else        begin m_mark[k] = p | q; m_neg[k] = !p && q; m_ami[k] = 1'b0; m_lbl[k] = "R5"; end
        if (!m_mark[k] && !zs_en) m_lbl[k] = "R7";
        if (zs_en && !rate_e1) begin
            run = 1'b1;
            for (int d = 0; d < 8; d++) if (!free_at(n - d)) run = 1'b0;
            if (run) begin
                // oldest first: 0 0 0 V B 0 V B
                for (int d = 0; d < 8; d++) begin
                    m_tag[(n - d) & 15] = (d == 1 || d == 4) ? 2 : ((d == 0 || d == 3) ? 3 : 1);
                    m_lbl[(n - d) & 15] = "R8";
                end
            end
        end else if (zs_en && rate_e1) begin
            run = 1'b1;
            for (int d = 0; d < 4; d++) if (!free_at(n - d)) run = 1'b0;
            if (run) begin
                for (int d = 0; d < 4; d++) begin
                    m_tag[(n - d) & 15] = (d == 0) ? 2 : ((d == 3) ? 4 : 1);
                    m_lbl[(n - d) & 15] = "R9";
                end
            end
        end
        k = (n - 8) & 15;
        e_neg = 1'b0;
        case (m_tag[k])
            0: begin e_mark = m_mark[k]; e_neg = m_ami[k] ? !last_neg : m_neg[k]; end
            2: begin e_mark = 1'b1; e_neg = last_neg; end
            3: begin e_mark = 1'b1; e_neg = !last_neg; end
            4: begin e_mark = !odd_cnt; e_neg = !last_neg; end
            default: e_mark = 1'b0;
        endcase
        lbl = m_lbl[k];
        if (e_mark) last_neg = e_neg;
        odd_cnt = (m_tag[k] == 2) ? 1'b0 : (odd_cnt ^ e_mark);
        widx = n + 1;
    endtask

    task automatic slot(input bit u, input bit a, input bit p, input bit q);
        bit    em, en;
        string lb;
        logic  hp, hn;
        @(negedge clk);
        uni_mode = u;
        alarm_on = a;
        if (lb_sel) begin
            loop_pos = p; loop_neg = q; loop_stb = 1'b1;
            norm_pos = 1'($urandom); norm_neg = 1'($urandom);
        end else begin
            norm_pos = p; norm_neg = q; norm_stb = 1'b1;
            loop_pos = 1'($urandom); loop_neg = 1'($urandom);
        end
        model_step(u, a, p, q, em, en, lb);
        @(negedge clk);
        norm_stb = 1'b0; loop_stb = 1'b0;
        chk(bit_stb === 1'b1 && {mark_p, mark_n} === {em && !en, em && en} && !(mark_p && mark_n),
            {lb, "/R3/R2/R10"}, {bit_stb, mark_p, mark_n}, {1'b1, em && !en, em && en});
        hp = mark_p; hn = mark_n;
        // strobe of the unselected source with junk data
        if (lb_sel) begin norm_stb = 1'b1; norm_pos = 1'($urandom); norm_neg = 1'($urandom); end
        else        begin loop_stb = 1'b1; loop_pos = 1'($urandom); loop_neg = 1'($urandom); end
        @(negedge clk);
        norm_stb = 1'b0; loop_stb = 1'b0;
        chk(bit_stb === 1'b0 && mark_p === hp && mark_n === hn, "R1",
            {bit_stb, mark_p, mark_n}, {1'b0, hp, hn});
    endtask

    task automatic uni_bits(input int cnt, input logic [31:0] pat);
        for (int i = cnt - 1; i >= 0; i--) slot(1'b1, 1'b0, pat[i], pat[i]);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_mark[i] = 1'b0; m_neg[i] = 1'b0; m_ami[i] = 1'b0;
            m_tag[i] = 1; m_lbl[i] = "R3";
        end
        widx = 8; last_neg = 1'b1; odd_cnt = 1'b0;
        void'($urandom(32'h1A2B3C4D));

        repeat (3) @(negedge clk);
        chk(mark_p === 1'b0 && mark_n === 1'b0 && bit_stb === 1'b0, "R11",
            {bit_stb, mark_p, mark_n}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mark_p === 1'b0 && mark_n === 1'b0 && bit_stb === 1'b0, "R11",
            {bit_stb, mark_p, mark_n}, 3'b000);

        // directed: delay and AMI, no substitution
        zs_en = 1'b0; rate_e1 = 1'b0;
        uni_bits(20, 20'b1000_0000_0110_0000_0001);
        // directed: B8ZS after marks of both polarities
        zs_en = 1'b1;
        uni_bits(18, 18'b10_0000_0000_1000_0000);
        uni_bits(24, 24'b0000_0000_0000_0000_1111_1111);
        // directed: HDB3 odd and even cases, long run
        rate_e1 = 1'b1;
        uni_bits(16, 16'b1000_0110_0001_0000);
        uni_bits(20, 20'b0000_0000_0000_1111_1111);
        // directed: bipolar given polarities with substitution
        slot(1'b0, 1'b0, 1'b0, 1'b1);
        slot(1'b0, 1'b0, 1'b0, 1'b1);
        repeat (8) slot(1'b0, 1'b0, 1'b0, 1'b0);
        rate_e1 = 1'b0;
        slot(1'b0, 1'b0, 1'b1, 1'b1);
        repeat (8) slot(1'b0, 1'b0, 1'b0, 1'b0);
        uni_bits(8, 8'hFF);

        // constrained random segments
        for (int seg = 0; seg < 30; seg++) begin
            @(negedge clk);
            lb_sel  = 1'($urandom);
            zs_en   = ($urandom % 4) != 0;
            rate_e1 = 1'($urandom);
            for (int s = 0; s < 40; s++) begin
                bit u, a, p, q;
                int r;
                u = ($urandom % 2) == 0;
                a = (seg % 5 == 3) && (($urandom % 6) != 0);
                r = $urandom % 8;
                if (u) begin p = (r == 0) || (r == 5); q = p; end
                else begin
                    p = (r == 5) || (r == 7);
                    q = (r == 6) || (r == 7 && ($urandom % 2 == 0));
                end
                slot(u, a, p, q);
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule